// File: doc/BRIEF.md
# Multi-Domain Programmable Clock Divider with Bypass

This block derives four clocks from one reference clock: a system clock, a peripheral clock, a cluster clock and a divided reference clock. Each output runs at the reference frequency divided by its own 10-bit integer divisor. The divisors come from an external register bank. A divisor of 0 or 1 passes the reference clock through unchanged.

A bypass input switches the system, peripheral and cluster outputs over to the raw reference clock. The divided reference output ignores bypass. The switch into bypass waits until the divided cycle in progress ends. The switch back out starts a fresh divided cycle. Neither switch produces a shortened pulse.

Three sources silence every output:
- an asynchronous active-low divider reset;
- an active-low bus reset;
- a control-register reset bit.

After silencing ends, each output restarts cleanly on the next reference rising edge.

Top module: `clkdiv_multi`

## Requirements
- R1: With an effective divisor N of 2 or more, an output repeats with a period of exactly N reference cycles.
- R2: A divisor value of 0 or 1 makes that output follow the reference clock (high while the reference is high, low while it is low).
- R3: Each divided cycle begins with its high phase. The high phase lasts floor(N/2) reference cycles and the low phase lasts the rest. Even N therefore gives 50% duty.
- R4: While bypass is in effect, the system, peripheral and cluster outputs follow the reference clock. The divided reference output (lane index 3) keeps dividing.
- R5: When bypass is requested, a dividing lane finishes its current divided cycle. It follows the reference clock from the first reference rising edge that ends that cycle.
- R6: When the bypass request drops, the lane leaves bypass at the next reference rising edge and starts a new divided cycle from count zero, high phase first.
- R7: A new divisor value takes effect only at the rising edge that ends the current divided cycle. No shortened cycle is produced.
- R8: While the divider reset input is low, all four outputs are low.
- R9: While the control reset bit is 1 or the bus reset is low, all four outputs are low. After release, the outputs stay low until the next reference rising edge, at which a new divided cycle starts with its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock |
| div_rst_ni | input | 1 | Asynchronous divider reset, active low |
| bus_rst_ni | input | 1 | Register-bus reset, active low |
| ctl_reset_i | input | 1 | Control-register reset bit, active high |
| bypass_i | input | 1 | Bypass request for the system, peripheral and cluster outputs |
| soc_div_i | input | DIV_W | System clock divisor |
| periph_div_i | input | DIV_W | Peripheral clock divisor |
| cluster_div_i | input | DIV_W | Cluster clock divisor |
| refdiv_div_i | input | DIV_W | Divided reference clock divisor |
| soc_clk_o | output | 1 | System clock |
| periph_clk_o | output | 1 | Peripheral clock |
| cluster_clk_o | output | 1 | Cluster clock |
| refdiv_clk_o | output | 1 | Divided reference clock |

## Verification
Divisor, bypass and release-from-reset inputs are sampled on a reference rising edge, and their effect on an output appears in the reference cycle that edge begins, or at the end of the current divided cycle where R5 and R7 defer it. The two resets and the control reset bit act combinationally on the outputs, so an output drops low immediately. The bench changes inputs late in the low phase of the reference clock. It advances its per-lane model at each rising edge and samples every output twice per reference cycle, once a quarter period after the rising edge and once a quarter period after the falling edge, so both phases of a pass-through output and every level of a divided output are compared in the cycle they are due.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum int {
      DOM_SOC     = 0,
      DOM_PERIPH  = 1,
      DOM_CLUSTER = 2,
      DOM_REFDIV  = 3
   } dom_e;

   localparam int NUM_DOMAINS = 4;

   // Only the three domain outputs honour the bypass request.
   function automatic bit dom_has_bypass(input int idx);
      return idx != int'(DOM_REFDIV);
   endfunction

endpackage

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
   input  logic div_rst_ni,
   input  logic bus_rst_ni,
   input  logic ctl_reset_i,
   output logic hold_o,
   output logic run_o
);

   // Synchronous silencing sources clear the lanes on the next edge.
   assign hold_o = ~bus_rst_ni | ctl_reset_i;
   // Combinational output enable from all three silencing sources.
   assign run_o  = div_rst_ni & ~hold_o;

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
   parameter int DIV_W   = 10,
   parameter bit HAS_BYP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic             bypass_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             q_o,
   output logic             byp_o,
   output logic             fresh_o,
   output logic             sel_ref_o,
   output logic [DIV_W-1:0] cnt_o,
   output logic [DIV_W-1:0] cur_o
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
      return (d <= ONE) ? ONE : d;
   endfunction

   logic             byp_req;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cur_q;
   logic             q_q;
   logic             byp_q;
   logic             fresh_q;

   logic [DIV_W-1:0] cur_eff;
   logic [DIV_W-1:0] hi_len;
   logic [DIV_W-1:0] cnt_inc;
   logic             at_end;

   generate
      if (HAS_BYP) begin : g_byp
         assign byp_req = bypass_i;
      end else begin : g_nobyp
         assign byp_req = 1'b0;
      end
   endgenerate

   assign cur_eff = eff_div(cur_q);
   assign hi_len  = cur_eff >> 1;
   assign cnt_inc = cnt_q + ONE;
   assign at_end  = (cnt_q == cur_eff - ONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         cur_q   <= '0;
         q_q     <= 1'b0;
         byp_q   <= 1'b0;
         fresh_q <= 1'b1;
      end else if (hold_i) begin
         cnt_q   <= '0;
         cur_q   <= '0;
         q_q     <= 1'b0;
         byp_q   <= 1'b0;
         fresh_q <= 1'b1;
      end else if (fresh_q) begin
         // First edge after silencing: start a divided cycle, high phase first.
         fresh_q <= 1'b0;
         cur_q   <= div_i;
         cnt_q   <= '0;
         q_q     <= 1'b1;
         byp_q   <= byp_req;
      end else if (byp_q) begin
         if (!byp_req) begin
            byp_q <= 1'b0;
            cur_q <= div_i;
            cnt_q <= '0;
            q_q   <= 1'b1;
         end
      end else if (at_end) begin
         // Cycle boundary: pick up a new divisor or enter bypass here only.
         cnt_q <= '0;
         cur_q <= div_i;
         q_q   <= 1'b1;
         byp_q <= byp_req;
      end else begin
         cnt_q <= cnt_inc;
         q_q   <= (cnt_inc < hi_len);
      end
   end

   assign q_o       = q_q;
   assign byp_o     = byp_q;
   assign fresh_o   = fresh_q;
   assign sel_ref_o = byp_q | (cur_eff == ONE);
   assign cnt_o     = cnt_q;
   assign cur_o     = cur_q;

endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel (
   input  logic ref_clk_i,
   input  logic en_i,
   input  logic sel_ref_i,
   input  logic div_q_i,
   output logic clk_o
);

   // Selection changes only on a reference rising edge, where the chosen
   // source and the other one are both at the start of a high level.
   assign clk_o = en_i & (sel_ref_i ? ref_clk_i : div_q_i);

endmodule

// File: rtl/clkdiv_multi.sv
module clkdiv_multi #(
   parameter int DIV_W = 10
) (
   input  logic             ref_clk_i,
   input  logic             div_rst_ni,
   input  logic             bus_rst_ni,
   input  logic             ctl_reset_i,
   input  logic             bypass_i,
   input  logic [DIV_W-1:0] soc_div_i,
   input  logic [DIV_W-1:0] periph_div_i,
   input  logic [DIV_W-1:0] cluster_div_i,
   input  logic [DIV_W-1:0] refdiv_div_i,
   output logic             soc_clk_o,
   output logic             periph_clk_o,
   output logic             cluster_clk_o,
   output logic             refdiv_clk_o
);

   localparam int LANES = clkdiv_pkg::NUM_DOMAINS;

   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
         $error("clkdiv_multi: DIV_W must lie in 2..16");
      end
   endgenerate

   logic                        hold;
   logic                        run;
   logic [LANES-1:0][DIV_W-1:0] lane_div;
   logic [LANES-1:0][DIV_W-1:0] lane_cnt;
   logic [LANES-1:0][DIV_W-1:0] lane_cur;
   logic [LANES-1:0]            lane_q;
   logic [LANES-1:0]            lane_byp;
   logic [LANES-1:0]            lane_fresh;
   logic [LANES-1:0]            lane_sel;
   logic [LANES-1:0]            lane_clk;

   assign lane_div[clkdiv_pkg::DOM_SOC]     = soc_div_i;
   assign lane_div[clkdiv_pkg::DOM_PERIPH]  = periph_div_i;
   assign lane_div[clkdiv_pkg::DOM_CLUSTER] = cluster_div_i;
   assign lane_div[clkdiv_pkg::DOM_REFDIV]  = refdiv_div_i;

   clkdiv_gate u_gate (
      .div_rst_ni  (div_rst_ni),
      .bus_rst_ni  (bus_rst_ni),
      .ctl_reset_i (ctl_reset_i),
      .hold_o      (hold),
      .run_o       (run)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      clkdiv_lane #(
         .DIV_W   (DIV_W),
         .HAS_BYP (clkdiv_pkg::dom_has_bypass(g))
      ) u_lane (
         .clk_i     (ref_clk_i),
         .rst_ni    (div_rst_ni),
         .hold_i    (hold),
         .bypass_i  (bypass_i),
         .div_i     (lane_div[g]),
         .q_o       (lane_q[g]),
         .byp_o     (lane_byp[g]),
         .fresh_o   (lane_fresh[g]),
         .sel_ref_o (lane_sel[g]),
         .cnt_o     (lane_cnt[g]),
         .cur_o     (lane_cur[g])
      );

      clkdiv_outsel u_outsel (
         .ref_clk_i (ref_clk_i),
         .en_i      (run & ~lane_fresh[g]),
         .sel_ref_i (lane_sel[g]),
         .div_q_i   (lane_q[g]),
         .clk_o     (lane_clk[g])
      );
   end

   assign soc_clk_o     = lane_clk[clkdiv_pkg::DOM_SOC];
   assign periph_clk_o  = lane_clk[clkdiv_pkg::DOM_PERIPH];
   assign cluster_clk_o = lane_clk[clkdiv_pkg::DOM_CLUSTER];
   assign refdiv_clk_o  = lane_clk[clkdiv_pkg::DOM_REFDIV];

endmodule

// File: rtl/clkdiv_multi_chk.sv
module clkdiv_multi_chk #(
   parameter int DIV_W = 10,
   parameter int LANES = 4
) (
   input logic                        ref_clk_i,
   input logic                        div_rst_ni,
   input logic                        bus_rst_ni,
   input logic                        ctl_reset_i,
   input logic [LANES-1:0]            clks,
   input logic [LANES-1:0]            byp_act,
   input logic [LANES-1:0]            fresh,
   input logic [LANES-1:0]            q,
   input logic [LANES-1:0][DIV_W-1:0] cnt,
   input logic [LANES-1:0][DIV_W-1:0] cur
);

   function automatic logic [DIV_W-1:0] chk_eff(input logic [DIV_W-1:0] d);
      return (d <= DIV_W'(1)) ? DIV_W'(1) : d;
   endfunction

   // R8: divider reset low silences every output.
   a_r8_outputs_low: assert property (@(negedge ref_clk_i) disable iff (!bus_rst_ni)
      !div_rst_ni |-> (clks == '0));

   // R9: control reset bit silences every output.
   a_r9_ctl_reset_low: assert property (@(negedge ref_clk_i) disable iff (!div_rst_ni)
      ctl_reset_i |-> (clks == '0));

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      // R1: count never leaves the active divide range.
      a_r1_count_in_range: assert property (@(posedge ref_clk_i) disable iff (!div_rst_ni)
         cnt[g] < chk_eff(cur[g]));

      // R4: a bypassed, running lane is high while the reference is high.
      a_r4_bypass_follows: assert property (@(negedge ref_clk_i) disable iff (!div_rst_ni)
         (byp_act[g] && !fresh[g] && bus_rst_ni && !ctl_reset_i) |-> clks[g]);

      // R5: bypass is entered only where a divided cycle ends.
      a_r5_enter_at_end: assert property (@(posedge ref_clk_i)
         disable iff (!div_rst_ni || !bus_rst_ni || ctl_reset_i)
         ($rose(byp_act[g]) && !$past(fresh[g])) |->
            ($past(cnt[g]) == chk_eff($past(cur[g])) - DIV_W'(1)));

      // R6: leaving bypass restarts the count with a high phase.
      a_r6_exit_restart: assert property (@(posedge ref_clk_i)
         disable iff (!div_rst_ni || !bus_rst_ni || ctl_reset_i)
         ($fell(byp_act[g]) && $past(bus_rst_ni) && !$past(ctl_reset_i)) |->
            (cnt[g] == '0 && q[g]));
   end

endmodule

bind clkdiv_multi clkdiv_multi_chk #(.DIV_W(DIV_W), .LANES(LANES)) u_chk (
   .ref_clk_i   (ref_clk_i),
   .div_rst_ni  (div_rst_ni),
   .bus_rst_ni  (bus_rst_ni),
   .ctl_reset_i (ctl_reset_i),
   .clks        (lane_clk),
   .byp_act     (lane_byp),
   .fresh       (lane_fresh),
   .q           (lane_q),
   .cnt         (lane_cnt),
   .cur         (lane_cur)
);

// File: tb/clkdiv_multi_tb_top.sv
module clkdiv_multi_tb_top;

   localparam int CLK_PERIOD = 20;
   localparam int DW         = 10;
   localparam int NL         = 4;

   logic          ref_clk = 1'b0;
   logic          div_rst_n;
   logic          bus_rst_n;
   logic          ctl_rst;
   logic          bypass;
   logic [DW-1:0] dv [NL];
   logic [NL-1:0] outs;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;
   string tag   = "R8";

   // bench model state per lane
   bit m_fresh [NL];
   bit m_byp   [NL];
   int m_pos   [NL];
   int m_n     [NL];

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

   clkdiv_multi #(.DIV_W(DW)) dut_i (
      .ref_clk_i     (ref_clk),
      .div_rst_ni    (div_rst_n),
      .bus_rst_ni    (bus_rst_n),
      .ctl_reset_i   (ctl_rst),
      .bypass_i      (bypass),
      .soc_div_i     (dv[0]),
      .periph_div_i  (dv[1]),
      .cluster_div_i (dv[2]),
      .refdiv_div_i  (dv[3]),
      .soc_clk_o     (outs[0]),
      .periph_clk_o  (outs[1]),
      .cluster_clk_o (outs[2]),
      .refdiv_clk_o  (outs[3])
   );

   function automatic int eff(input logic [DW-1:0] d);
      return (d <= 1) ? 1 : int'(d);
   endfunction

   function automatic bit silenced();
      return !div_rst_n || !bus_rst_n || ctl_rst;
   endfunction

   // Expected level of lane i in the high (1) or low (0) reference phase.
   function automatic bit exp_level(input int i, input bit ref_high);
      if (silenced() || m_fresh[i]) return 1'b0;
      if (m_byp[i] || m_n[i] == 1) return ref_high;
      return m_pos[i] < (m_n[i] / 2);
   endfunction

   // Advance the model at a reference rising edge (R1 R3 R5 R6 R7 R9).
   function automatic void model_edge();
      for (int i = 0; i < NL; i++) begin
         bit hb = (i != 3);
         if (silenced()) begin
            m_fresh[i] = 1'b1; m_byp[i] = 1'b0; m_pos[i] = 0; m_n[i] = 1;
         end else if (m_fresh[i]) begin
            m_fresh[i] = 1'b0; m_n[i] = eff(dv[i]); m_pos[i] = 0; m_byp[i] = hb && bypass;
         end else if (m_byp[i]) begin
            if (!bypass) begin
               m_byp[i] = 1'b0; m_pos[i] = 0; m_n[i] = eff(dv[i]);
            end
         end else if (m_pos[i] == m_n[i] - 1) begin
            m_pos[i] = 0; m_n[i] = eff(dv[i]);
            if (hb && bypass) m_byp[i] = 1'b1;
         end else begin
            m_pos[i]++;
         end
      end
   endfunction

   task automatic check_all(input bit ref_high);
      for (int i = 0; i < NL; i++) begin
         bit e = exp_level(i, ref_high);
         n_checks++;
         if (outs[i] !== e) begin
            n_fails++;
            $display("FAIL %s lane %0d phase %s: got %b expected %b at %0t",
                     tag, i, ref_high ? "high" : "low", outs[i], e, $time);
         end
      end
   endtask

   // One reference cycle: model at the edge, sample both phases,
   // return late in the low phase for the caller to drive inputs.
   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge ref_clk);
         model_edge();
         #(CLK_PERIOD/4);
         check_all(1'b1);
         #(CLK_PERIOD/2);
         check_all(1'b0);
         #(CLK_PERIOD/4 - 2);
      end
   endtask

   function automatic logic [DW-1:0] pick_div();
      int r = int'($urandom % 8);
      if (r < 2) return DW'($urandom % 2);
      return DW'(2 + ($urandom % 30));
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < NL; i++) begin
         m_fresh[i] = 1'b1; m_byp[i] = 1'b0; m_pos[i] = 0; m_n[i] = 1;
      end
      div_rst_n = 1'b0; bus_rst_n = 1'b0; ctl_rst = 1'b0; bypass = 1'b0;
      dv[0] = 10'd4; dv[1] = 10'd3; dv[2] = 10'd0; dv[3] = 10'd40;
      #(CLK_PERIOD/2 + CLK_PERIOD/2 - 2);

      tag = "R8 reset state";        step(3);
      div_rst_n = 1'b1;
      tag = "R9 bus reset";          step(3);
      bus_rst_n = 1'b1;
      tag = "R1 R3 R2 mixed";        step(120);

      dv[0] = 10'd1; dv[1] = 10'd0;
      tag = "R2 pass-through";       step(30);

      dv[0] = 10'd8; dv[1] = 10'd7;
      tag = "R7 R3 new divisor";     step(13);
      dv[0] = 10'd5; dv[1] = 10'd2;
      tag = "R7 change mid-cycle";   step(40);

      step(2);
      bypass = 1'b1;
      tag = "R5 R4 enter bypass";    step(30);
      bypass = 1'b0;
      tag = "R6 exit bypass";        step(40);

      ctl_rst = 1'b1;
      tag = "R9 control reset";      step(5);
      ctl_rst = 1'b0;
      tag = "R9 release";            step(20);

      step(3);
      div_rst_n = 1'b0;
      tag = "R8 divider reset";      step(3);
      div_rst_n = 1'b1;
      tag = "R8 release";            step(20);

      dv[3] = 10'd1023;
      step(50);
      tag = "R1 max divisor";        step(2100);

      tag = "R1 R3 R4 random";
      for (int s = 0; s < 60; s++) begin
         for (int i = 0; i < NL; i++) dv[i] = pick_div();
         if (($urandom % 3) == 0) bypass = ~bypass;
         if (($urandom % 10) == 0) begin
            ctl_rst = 1'b1; step(2); ctl_rst = 1'b0;
         end
         step(40 + int'($urandom % 80));
      end

      finish_run();
   end

endmodule